// File: doc/BRIEF.md
# Multi-Source Reset Controller with Bus-Cycle Deferral

This block collects reset requests from six sources and turns them into one registered system reset. Three of the sources are catastrophic: power-on, software watchdog expiry and the halt monitor. They reset the system as soon as they have crossed into the clock domain. The other three are bus-friendly: the external reset pin, loss-of-clock detection and the test request. These wait until the bus cycle in flight finishes, so that a write in progress is not torn.

While a bus-friendly request is waiting, the bus monitor is forced on, whatever its configured enable. If the cycle hangs, the monitor ends it with a one-clock bus-error pulse, and the pending reset is then let through. Once asserted, the system reset is held for a fixed number of clocks after the last request goes away. A one-hot cause register records what started the latest reset. It is cleared only by power-on.

The block's own synchronous reset input `rst` is the power-on request. The other five request inputs are asynchronous and pass through a two-flop synchronizer.

Top module: `rstc_top`

## Requirements
- R1: While `rst` is high, `sys_rst_o` is 1 and `rst_cause_o` is 6'b000001. After `rst` is released, `sys_rst_o` falls on the 16th rising edge that samples `rst` low, counting the first such edge as 1.
- R2: Watchdog (`wdog_req`) and halt (`halt_req`) requests are immediate. `sys_rst_o` reads 1 after the third rising edge that samples the request high, whatever the bus inputs are.
- R3: External, clock-fail and test requests reach `sys_rst_o` with the same three-edge latency when the bus is free. The bus is free when `bus_active` is 0, or `bus_term` is 1, or `bus_err_o` is 1.
- R4: A bus-friendly request is held back while `bus_active`=1 and `bus_term`=0. `sys_rst_o` rises on the first edge that samples `bus_term` high.
- R5: While a bus-friendly request waits on a hung cycle, the bus monitor runs even if `bmon_cfg_en`=0. With the default limit of 64, `bus_err_o` reads 1 after edge 66 counted from the first edge that samples the request, and `sys_rst_o` rises one edge later.
- R6: With `bmon_cfg_en`=1 and a cycle hung from edge 1, `bus_err_o` reads 1 after edge 64, for exactly one clock. It does not reset the system. With `bmon_cfg_en`=0 and no request pending, `bus_err_o` stays 0.
- R7: After every request input is sampled low, `sys_rst_o` falls on the 18th rising edge, counting the first such edge as 1. Two of these edges are synchronization and 16 are the stretch.
- R8: `rst_cause_o` is one-hot. Bit 0 is power-on, bit 1 external, bit 2 watchdog, bit 3 halt, bit 4 clock fail, bit 5 test. Among requests released on the same edge, the lowest bit wins.
- R9: The cause register keeps its value across non-power-on resets, and a later reset overwrites it. Only `rst` resets it to 6'b000001.
- R10: Requests that arrive while `sys_rst_o` is already high extend the reset but do not change `rst_cause_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on request, synchronous active high |
| ext_rst_req | input | 1 | External pin request, bus-friendly |
| wdog_req | input | 1 | Watchdog timeout request, immediate |
| halt_req | input | 1 | Halt monitor request, immediate |
| clkfail_req | input | 1 | Loss-of-clock request, bus-friendly |
| test_req | input | 1 | Test request, bus-friendly |
| bus_active | input | 1 | A bus cycle is in progress |
| bus_term | input | 1 | The current bus cycle terminates this clock |
| bmon_cfg_en | input | 1 | Configured enable of the bus monitor |
| bus_err_o | output | 1 | Bus-error termination pulse from the monitor |
| sys_rst_o | output | 1 | Stretched system reset |
| rst_cause_o | output | 6 | One-hot cause of the most recent reset |

## Verification
The bench targets the timing of the deferral. A design that ignores the bus would reset in the middle of a hung cycle. One that never forces the monitor on would wait forever on a cycle that does not end. One that gates the immediate sources on the bus would delay a watchdog reset. It also combines an immediate request with a waiting, higher-priority bus-friendly one, and expects the immediate source as the cause. A priority encoder that looked at raw rather than released requests would report the external pin there. Late requests during an active reset, cause retention across resets, and the exact stretch length are each checked cycle for cycle, so an off-by-one counter or a cause register cleared by every reset shows up.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NSRC    = 6;
  localparam int SRC_POR = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_WDG = 2;
  localparam int SRC_HLT = 3;
  localparam int SRC_CLK = 4;
  localparam int SRC_TST = 5;
  // bits set here wait for the end of the bus cycle
  localparam logic [NSRC-1:0] SYNC_MASK_DEF =
    (NSRC'(1) << SRC_EXT) | (NSRC'(1) << SRC_CLK) | (NSRC'(1) << SRC_TST);
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rstc_busmon.sv
module rstc_busmon #(
  parameter int W     = 8,
  parameter int LIMIT = 64   // 2 .. 2**W-1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bus_active,
  input  logic bus_term,
  output logic bus_err
);
  logic [W-1:0] cnt;
  logic         hung;

  assign hung = en && bus_active && !bus_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bus_err <= 1'b0;
    end else if (hung) begin
      if (cnt == W'(LIMIT - 1)) begin
        cnt     <= '0;
        bus_err <= 1'b1;
      end else begin
        cnt     <= cnt + 1'b1;
        bus_err <= 1'b0;
      end
    end else begin
      cnt     <= '0;
      bus_err <= 1'b0;
    end
  end
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [N-1:0] fire_vec,
  output logic [N-1:0] cause
);
  logic [N-1:0] pick;

  // lowest set bit wins
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign pick[i] = fire_vec[i];
    end else begin : g_rest
      assign pick[i] = fire_vec[i] && !(|fire_vec[i-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cause <= N'(1);
    else if (capture) cause <= pick;
  end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter logic [NSRC-1:0] SYNC_MASK = SYNC_MASK_DEF,
  parameter int              STRETCH   = 16,
  parameter int              BMON_W    = 8,
  parameter int              BMON_LIM  = 64,
  parameter int              SYNC_STG  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_rst_req,
  input  logic            wdog_req,
  input  logic            halt_req,
  input  logic            clkfail_req,
  input  logic            test_req,
  input  logic            bus_active,
  input  logic            bus_term,
  input  logic            bmon_cfg_en,
  output logic            bus_err_o,
  output logic            sys_rst_o,
  output logic [NSRC-1:0] rst_cause_o
);
  localparam int CW = $clog2(STRETCH + 1);

  logic [NSRC-2:0] raw_req, req_s;
  logic [NSRC-1:0] req_sync, fire_vec;
  logic            bus_free, sync_any, sync_pend, fire, active, capture, bmon_en;
  logic [CW-1:0]   cnt;
  logic            rst_q;

  assign raw_req = {test_req, clkfail_req, halt_req, wdog_req, ext_rst_req};

  rstc_sync #(.W(NSRC-1), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(raw_req), .q(req_s)
  );

  assign req_sync  = {req_s, 1'b0};
  assign bus_free  = !bus_active || bus_term || bus_err_o;
  assign sync_any  = |(req_sync & SYNC_MASK);
  assign sync_pend = sync_any && !rst_q;
  assign bmon_en   = bmon_cfg_en || sync_pend;
  assign fire_vec  = req_sync & (~SYNC_MASK | {NSRC{bus_free}});
  assign fire      = |fire_vec;
  assign active    = rst_q ? (|req_sync) : fire;
  assign capture   = fire && !rst_q;

  rstc_busmon #(.W(BMON_W), .LIMIT(BMON_LIM)) u_bmon (
    .clk(clk), .rst(rst), .en(bmon_en),
    .bus_active(bus_active), .bus_term(bus_term), .bus_err(bus_err_o)
  );

  rstc_cause #(.N(NSRC)) u_cause (
    .clk(clk), .rst(rst), .capture(capture),
    .fire_vec(fire_vec), .cause(rst_cause_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= CW'(STRETCH);
      rst_q <= 1'b1;
    end else if (active) begin
      cnt   <= CW'(STRETCH);
      rst_q <= 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      rst_q <= (cnt > CW'(1));
    end
  end

  assign sys_rst_o = rst_q;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
  parameter logic [5:0] SYNC_MASK = 6'b110010
) (
  input logic       clk,
  input logic       rst,
  input logic [5:0] req_sync,
  input logic       bus_active,
  input logic       bus_term,
  input logic       bus_err,
  input logic       sys_rst,
  input logic [5:0] cause
);
  p_cause_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(cause) == 1);

  p_async_fires_r2: assert property (@(posedge clk) disable iff (rst)
    (|(req_sync & ~SYNC_MASK)) |=> sys_rst);

  p_hold_sync_r4: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst && bus_active && !bus_term && !bus_err &&
     !(|(req_sync & ~SYNC_MASK))) |=> !sys_rst);

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> !bus_err);

  p_stretch_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> ($past(req_sync) == 6'b0));

  p_cause_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (sys_rst && $past(sys_rst)) |-> $stable(cause));
endmodule

bind rstc_top rstc_checker #(.SYNC_MASK(SYNC_MASK)) u_chk (
  .clk(clk), .rst(rst), .req_sync(req_sync), .bus_active(bus_active),
  .bus_term(bus_term), .bus_err(bus_err_o), .sys_rst(sys_rst_o),
  .cause(rst_cause_o)
);

// File: tb/rstc_top_test.sv
`timescale 1ns/1ps
module rstc_top_test;
  logic clk = 1'b0;
  logic rst, ext_rst_req, wdog_req, halt_req, clkfail_req, test_req;
  logic bus_active, bus_term, bmon_cfg_en;
  logic bus_err_o, sys_rst_o;
  logic [5:0] rst_cause_o;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  rstc_top uut (
    .clk(clk), .rst(rst), .ext_rst_req(ext_rst_req), .wdog_req(wdog_req),
    .halt_req(halt_req), .clkfail_req(clkfail_req), .test_req(test_req),
    .bus_active(bus_active), .bus_term(bus_term), .bmon_cfg_en(bmon_cfg_en),
    .bus_err_o(bus_err_o), .sys_rst_o(sys_rst_o), .rst_cause_o(rst_cause_o)
  );

  // req bits: [0] ext, [1] wdog, [2] halt, [3] clkfail, [4] test
  typedef struct packed {
    logic [4:0] req;
    logic       act;
    logic       term;
    logic [7:0] lat;
    logic [5:0] cause;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'b00010, 1'b0, 1'b0, 8'd3, 6'b000100},  // watchdog, idle bus
    '{5'b00100, 1'b1, 1'b0, 8'd3, 6'b001000},  // halt ignores hung bus
    '{5'b00001, 1'b0, 1'b0, 8'd3, 6'b000010},  // external, idle bus
    '{5'b01000, 1'b1, 1'b1, 8'd3, 6'b010000},  // clock fail, cycle ending
    '{5'b10000, 1'b0, 1'b0, 8'd3, 6'b100000},  // test, idle bus
    '{5'b10001, 1'b0, 1'b0, 8'd3, 6'b000010},  // ext beats test
    '{5'b00011, 1'b1, 1'b0, 8'd3, 6'b000100},  // ext held back, wdog wins
    '{5'b01100, 1'b1, 1'b0, 8'd3, 6'b001000}   // clkfail held back, halt wins
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [4:0] r);
    ext_rst_req = r[0];
    wdog_req    = r[1];
    halt_req    = r[2];
    clkfail_req = r[3];
    test_req    = r[4];
  endtask

  // count edges until sig samples the given value
  task automatic edges_until_rst(input logic val, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (sys_rst_o !== val && n < 300);
  endtask

  task automatic drop_and_wait;
    int n;
    set_req(5'b0);
    bus_active = 1'b0; bus_term = 1'b0;
    if (sys_rst_o) edges_until_rst(1'b0, n);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; set_req(5'b0);
    bus_active = 1'b0; bus_term = 1'b0; bmon_cfg_en = 1'b0;
    repeat (4) @(negedge clk);
    // R1: power-on state
    chk("R1 rst out during por", 32'(sys_rst_o), 32'd1);
    chk("R1 cause during por", 32'(rst_cause_o), 32'h01);
    chk("R6 no bus error in reset", 32'(bus_err_o), 32'd0);
    rst = 1'b0;
    edges_until_rst(1'b0, n);
    chk("R1 por release length", 32'(n), 32'd16);
    chk("R9 por cause kept after release", 32'(rst_cause_o), 32'h01);
    repeat (2) @(negedge clk);

    // vector table: latency, cause and stretch (R2 R3 R7 R8)
    foreach (VECS[i]) begin
      set_req(VECS[i].req);
      bus_active = VECS[i].act;
      bus_term   = VECS[i].term;
      edges_until_rst(1'b1, n);
      chk("R2/R3 assert latency", 32'(n), 32'(VECS[i].lat));
      chk("R8 cause", 32'(rst_cause_o), 32'(VECS[i].cause));
      @(negedge clk);
      set_req(5'b0);
      bus_active = 1'b0; bus_term = 1'b0;
      edges_until_rst(1'b0, n);
      chk("R7 stretch length", 32'(n), 32'd18);
      chk("R9 cause survives", 32'(rst_cause_o), 32'(VECS[i].cause));
      repeat (2) @(negedge clk);
    end

    // R4: external request held until bus_term
    bus_active = 1'b1; bus_term = 1'b0;
    set_req(5'b00001);
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk("R4 held while cycle hung", 32'(sys_rst_o), 32'd0);
    bus_term = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R4 released at termination", 32'(sys_rst_o), 32'd1);
    chk("R4 cause ext", 32'(rst_cause_o), 32'h02);
    drop_and_wait();

    // R5: forced monitor ends a hung cycle
    bmon_cfg_en = 1'b0; bus_active = 1'b1; bus_term = 1'b0;
    set_req(5'b10000);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (bus_err_o !== 1'b1 && n < 300);
    chk("R5 forced bus error edge", 32'(n), 32'd66);
    chk("R5 reset not yet", 32'(sys_rst_o), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R5 reset after bus error", 32'(sys_rst_o), 32'd1);
    chk("R5 cause test", 32'(rst_cause_o), 32'h20);
    drop_and_wait();

    // R6: configured monitor, no reset
    bmon_cfg_en = 1'b1; bus_active = 1'b1; bus_term = 1'b0;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (bus_err_o !== 1'b1 && n < 300);
    chk("R6 configured timeout edge", 32'(n), 32'd64);
    chk("R6 no reset from bus error", 32'(sys_rst_o), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R6 error is one clock", 32'(bus_err_o), 32'd0);
    bmon_cfg_en = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); @(negedge clk);
      if (bus_err_o) n++;
    end
    chk("R6 monitor off stays quiet", 32'(n), 32'd0);
    bus_active = 1'b0;
    repeat (2) @(negedge clk);

    // R10: late request during active reset
    set_req(5'b00010);
    edges_until_rst(1'b1, n);
    chk("R10 wdog reset", 32'(rst_cause_o), 32'h04);
    set_req(5'b00001);
    repeat (6) @(negedge clk);
    chk("R10 cause frozen", 32'(rst_cause_o), 32'h04);
    set_req(5'b0);
    edges_until_rst(1'b0, n);
    chk("R10 late request extends", 32'(n), 32'd18);
    chk("R10 cause after release", 32'(rst_cause_o), 32'h04);
    repeat (2) @(negedge clk);

    // R9: later reset overwrites, por clears
    set_req(5'b00100);
    edges_until_rst(1'b1, n);
    chk("R9 overwrite by halt", 32'(rst_cause_o), 32'h08);
    drop_and_wait();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 por resets cause", 32'(rst_cause_o), 32'h01);
    chk("R1 por asserts reset", 32'(sys_rst_o), 32'd1);
    rst = 1'b0;
    edges_until_rst(1'b0, n);
    chk("R1 second por release", 32'(n), 32'd16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule